// File: doc/BRIEF.md
# SPI Flash Transaction Sequencer

This block is an SPI master that carries out exactly one flash transaction for each accepted request. The transaction selects the device, shifts out a command of one to five bytes taken from a command buffer, then either shifts out or shifts in a given number of data bytes, and finally deselects the device. Write data arrives one byte at a time on a byte input with a take strobe. Read data leaves one byte at a time on a byte output with a valid strobe.

After chip select is released the block enforces a minimum deselect interval before the next transaction can start. The length of that interval is one of three programmable counts, picked per transaction by a class code: read, modify (erase, program, register write) or other. Clock polarity follows the selected SPI mode (0 or 3). An external hold request pauses a running transaction without releasing chip select, and signals the pause to the device on an active-low hold pin. Higher layers choose the command length, for example 4 or 5 bytes depending on the address width.

Top module: `spi_xact_engine`

## Requirements
- R1: An accepted request drives csN low on the next clock edge. csN then stays low without a break for exactly 16*DIV*(cmdLen+dataLen) clock cycles, plus one cycle for each cycle the transaction is held. Bytes go out MSB first: the command bytes first, in the order cmdBuf[7:0], cmdBuf[15:8] and so on up to cmdLen bytes, then the data bytes.
- R2: Each bit lasts DIV clock cycles with sclk at its low level, then DIV cycles with sclk high. A transaction gives exactly 8*(cmdLen+dataLen) rising sclk edges. Outside a transaction sclk rests low when mode3=0 and high when mode3=1.
- R3: In a write (isRead=0), each data byte is taken from txData when that byte starts. txTake pulses for one cycle after each take, so there are dataLen pulses per write and none in a read.
- R4: In a read (isRead=1), miso is sampled on each rising sclk edge. rxValid pulses once per data byte, with the byte on rxData, dataLen times in all. miso is ignored during the command phase and during writes, so no rxValid appears there. mosi is held at 0 while read data is shifted in.
- R5: dataLen=0 gives a command-only transaction: only the command bytes are shifted, and there are no txTake or rxValid pulses.
- R6: The deselect count is dselOther for dselClass 0 or 3, dselRead for class 1 and dselProg for class 2. busy stays high while the count runs out after csN rises. With the next request already waiting, csN stays high for exactly count+2 clock cycles.
- R7: A request is accepted only while busy is low. A request raised while busy is ignored and starts no further transaction.
- R8: While holdReq is high during a transaction, holdN is low, sclk and all shifting are frozen, and csN stays low. The transaction then resumes and completes with the same data. holdN is high at all other times.
- R9: After reset, csN=1, holdN=1, busy=0, txTake=0 and rxValid=0, and sclk rests at the level set by mode3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start request, accepted when not busy |
| busy | output | 1 | Transaction or deselect interval in progress |
| mode3 | input | 1 | 1 selects SPI mode 3, 0 selects mode 0 |
| cmdBuf | input | 8*CMD_BYTES | Command bytes, byte 0 in the low bits |
| cmdLen | input | $clog2(CMD_BYTES+1) | Number of command bytes, 1..CMD_BYTES |
| dataLen | input | LEN_W | Number of data bytes, may be 0 |
| isRead | input | 1 | 1 receives data bytes, 0 transmits them |
| dselClass | input | 2 | Deselect class: 0/3 other, 1 read, 2 modify |
| dselOther | input | DSEL_W | Deselect count for other operations |
| dselRead | input | DSEL_W | Deselect count for reads |
| dselProg | input | DSEL_W | Deselect count for erase/program/write |
| txData | input | 8 | Next write data byte |
| txTake | output | 1 | Write byte consumed pulse |
| rxData | output | 8 | Received data byte |
| rxValid | output | 1 | rxData valid pulse |
| holdReq | input | 1 | Request to pause the running transaction |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |
| holdN | output | 1 | Hold pin to device, active low |

## Verification
All command lengths from 1 to 5 are swept against data lengths 0 to 3, both directions and both SPI modes. Byte order is checked with distinct values per position, so swapped or reversed bytes show up. Frame length and edge counts expose phase miscounts. miso carries ones during command bytes, so reads expose any sampling outside the data phase. A back-to-back request stream for each deselect class measures the chip-select gap, which separates the three counts and the class decode. A hold in mid-frame and a request raised while busy check that pausing changes only timing and that stray requests are dropped.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DESEL = 2'd2
  } xactState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // load next byte into the transmit shifter
    logic run;        // bit engine active
    logic freeze;     // pause bit engine (hold)
    logic deselLoad;  // load deselect counter
    logic deselRun;   // count deselect interval
  } xactStrobes_t;

endpackage

// File: rtl/spi_xact_dpath.sv
module spi_xact_dpath
  import spi_xact_pkg::*;
#(
  parameter int DIV    = 2,
  parameter int DSEL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xactStrobes_t      strb,
  input  logic [7:0]        ldByte,
  input  logic [DSEL_W-1:0] deselVal,
  input  logic              cpolLvl,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              byteEnd,
  output logic [7:0]        rxByte,
  output logic              deselZero
);

  localparam int DIVC_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [7:0]        txShift;
  logic [7:0]        rxShift;
  logic [2:0]        bitCnt;
  logic              phaseB;
  logic              tick;
  logic [DSEL_W-1:0] deselCnt;

  // half-period divider; a parameter picks the variant
  generate
    if (DIV == 1) begin : g_noDiv
      assign tick = strb.run && !strb.freeze;
    end else begin : g_div
      localparam logic [DIVC_W-1:0] DIV_LAST = DIVC_W'(DIV - 1);
      logic [DIVC_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (strb.load) begin
          divCnt <= '0;
        end else if (strb.run && !strb.freeze) begin
          if (divCnt == DIV_LAST) divCnt <= '0;
          else                    divCnt <= divCnt + DIVC_W'(1);
        end
      end
      assign tick = strb.run && !strb.freeze && (divCnt == DIV_LAST);
    end
  endgenerate

  assign byteEnd = tick && phaseB && (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      bitCnt  <= '0;
      phaseB  <= 1'b0;
    end else if (strb.load) begin
      txShift <= ldByte;
      bitCnt  <= '0;
      phaseB  <= 1'b0;
    end else if (tick) begin
      phaseB <= !phaseB;
      if (!phaseB) begin
        rxShift <= {rxShift[6:0], miso};
      end else begin
        bitCnt  <= bitCnt + 3'd1;
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deselCnt <= '0;
    end else if (strb.deselLoad) begin
      deselCnt <= deselVal;
    end else if (strb.deselRun && (deselCnt != '0)) begin
      deselCnt <= deselCnt - DSEL_W'(1);
    end
  end

  assign deselZero = (deselCnt == '0);
  assign sclk      = strb.run ? phaseB : cpolLvl;
  assign mosi      = strb.run ? txShift[7] : 1'b0;
  assign rxByte    = rxShift;

endmodule

// File: rtl/spi_xact_ctrl.sv
module spi_xact_ctrl
  import spi_xact_pkg::*;
#(
  parameter int CMD_BYTES = 5,
  parameter int LEN_W     = 8,
  parameter int DSEL_W    = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  input  logic                               mode3,
  input  logic [8*CMD_BYTES-1:0]             cmdBuf,
  input  logic [$clog2(CMD_BYTES+1)-1:0]     cmdLen,
  input  logic [LEN_W-1:0]                   dataLen,
  input  logic                               isRead,
  input  logic [1:0]                         dselClass,
  input  logic [DSEL_W-1:0]                  dselOther,
  input  logic [DSEL_W-1:0]                  dselRead,
  input  logic [DSEL_W-1:0]                  dselProg,
  input  logic [7:0]                         txData,
  input  logic                               holdReq,
  input  logic                               byteEnd,
  input  logic                               deselZero,
  output xactStrobes_t                       strb,
  output logic [7:0]                         ldByte,
  output logic [DSEL_W-1:0]                  deselVal,
  output logic                               cpolLvl,
  output logic                               csN,
  output logic                               busy,
  output logic                               holdN,
  output logic                               txTake,
  output logic                               rxValid
);

  localparam int CLEN_W = $clog2(CMD_BYTES + 1);
  localparam int TOT_W  = LEN_W + 1;

  xactState_e             state;
  logic [8*CMD_BYTES-1:0] cmdReg;
  logic [CLEN_W-1:0]      cmdLenReg;
  logic [TOT_W-1:0]       totReg;
  logic [TOT_W-1:0]       idxReg;
  logic                   readReg;
  logic [1:0]             classReg;
  logic                   modeReg;

  logic             accept;
  logic [TOT_W-1:0] nextIdx;
  logic             lastByte;
  logic             nextIsCmd;
  logic             curDataRd;
  logic [7:0]       cmdByteSel;
  logic             inShift;

  assign inShift   = (state == ST_SHIFT);
  assign accept    = (state == ST_IDLE) && reqValid;
  assign nextIdx   = idxReg + TOT_W'(1);
  assign lastByte  = (nextIdx == totReg);
  assign nextIsCmd = (nextIdx < TOT_W'(cmdLenReg));
  assign curDataRd = readReg && (idxReg >= TOT_W'(cmdLenReg));

  always_comb begin
    cmdByteSel = '0;
    for (int i = 0; i < CMD_BYTES; i++) begin
      if (nextIdx == TOT_W'(i)) cmdByteSel = cmdReg[8*i +: 8];
    end
  end

  always_comb begin
    if (accept)         ldByte = cmdBuf[7:0];
    else if (nextIsCmd) ldByte = cmdByteSel;
    else if (readReg)   ldByte = 8'h00;
    else                ldByte = txData;
  end

  always_comb begin
    case (classReg)
      2'd1:    deselVal = dselRead;
      2'd2:    deselVal = dselProg;
      default: deselVal = dselOther;
    endcase
  end

  always_comb begin
    strb.load      = accept || (inShift && byteEnd && !lastByte);
    strb.run       = inShift;
    strb.freeze    = inShift && holdReq;
    strb.deselLoad = inShift && byteEnd && lastByte;
    strb.deselRun  = (state == ST_DESEL);
  end

  assign cpolLvl = (state == ST_IDLE) ? mode3 : modeReg;
  assign busy    = (state != ST_IDLE);
  assign holdN   = !(inShift && holdReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cmdReg    <= '0;
      cmdLenReg <= '0;
      totReg    <= '0;
      idxReg    <= '0;
      readReg   <= 1'b0;
      classReg  <= '0;
      modeReg   <= 1'b0;
      csN       <= 1'b1;
      txTake    <= 1'b0;
      rxValid   <= 1'b0;
    end else begin
      txTake  <= inShift && byteEnd && !lastByte && !nextIsCmd && !readReg;
      rxValid <= inShift && byteEnd && curDataRd;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state     <= ST_SHIFT;
            cmdReg    <= cmdBuf;
            cmdLenReg <= cmdLen;
            totReg    <= TOT_W'(cmdLen) + TOT_W'(dataLen);
            idxReg    <= '0;
            readReg   <= isRead;
            classReg  <= dselClass;
            modeReg   <= mode3;
            csN       <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (byteEnd) begin
            if (lastByte) begin
              state <= ST_DESEL;
              csN   <= 1'b1;
            end else begin
              idxReg <= nextIdx;
            end
          end
        end
        ST_DESEL: begin
          if (deselZero) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
  import spi_xact_pkg::*;
#(
  parameter int CMD_BYTES = 5,
  parameter int LEN_W     = 8,
  parameter int DIV       = 2,
  parameter int DSEL_W    = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  output logic                           busy,
  input  logic                           mode3,
  input  logic [8*CMD_BYTES-1:0]         cmdBuf,
  input  logic [$clog2(CMD_BYTES+1)-1:0] cmdLen,
  input  logic [LEN_W-1:0]               dataLen,
  input  logic                           isRead,
  input  logic [1:0]                     dselClass,
  input  logic [DSEL_W-1:0]              dselOther,
  input  logic [DSEL_W-1:0]              dselRead,
  input  logic [DSEL_W-1:0]              dselProg,
  input  logic [7:0]                     txData,
  output logic                           txTake,
  output logic [7:0]                     rxData,
  output logic                           rxValid,
  input  logic                           holdReq,
  output logic                           csN,
  output logic                           sclk,
  output logic                           mosi,
  input  logic                           miso,
  output logic                           holdN
);

  xactStrobes_t      strb;
  logic [7:0]        ldByte;
  logic [DSEL_W-1:0] deselVal;
  logic              cpolLvl;
  logic              byteEnd;
  logic              deselZero;

  spi_xact_ctrl #(
    .CMD_BYTES(CMD_BYTES), .LEN_W(LEN_W), .DSEL_W(DSEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode3(mode3),
    .cmdBuf(cmdBuf), .cmdLen(cmdLen), .dataLen(dataLen), .isRead(isRead),
    .dselClass(dselClass), .dselOther(dselOther), .dselRead(dselRead),
    .dselProg(dselProg), .txData(txData), .holdReq(holdReq),
    .byteEnd(byteEnd), .deselZero(deselZero), .strb(strb), .ldByte(ldByte),
    .deselVal(deselVal), .cpolLvl(cpolLvl), .csN(csN), .busy(busy),
    .holdN(holdN), .txTake(txTake), .rxValid(rxValid)
  );

  spi_xact_dpath #(
    .DIV(DIV), .DSEL_W(DSEL_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ldByte(ldByte),
    .deselVal(deselVal), .cpolLvl(cpolLvl), .miso(miso), .sclk(sclk),
    .mosi(mosi), .byteEnd(byteEnd), .rxByte(rxData), .deselZero(deselZero)
  );

endmodule

// File: rtl/spi_xact_chk.sv
module spi_xact_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic busy,
  input logic csN,
  input logic sclk,
  input logic holdReq,
  input logic holdN,
  input logic txTake,
  input logic rxValid
);

  AST_SELECT_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy); // R1

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> ($past(!busy) && $past(reqValid))); // R7

  AST_HOLD_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !holdN |-> (!csN && holdReq)); // R8

  AST_HOLD_FREEZES_SCLK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(holdReq) && $past(!csN) && !csN) |-> $stable(sclk)); // R8

  AST_RX_IN_XFER: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> busy); // R4

  AST_TAKE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> !csN); // R3

  AST_BUSY_AT_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> busy); // R6

endmodule

bind spi_xact_engine spi_xact_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .csN(csN),
  .sclk(sclk), .holdReq(holdReq), .holdN(holdN), .txTake(txTake),
  .rxValid(rxValid)
);

// File: tb/spi_xact_engine_tb.sv
module spi_xact_engine_tb;

  localparam int DIV = 2;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        busy;
  logic        mode3 = 1'b0;
  logic [39:0] cmdBuf = '0;
  logic [2:0]  cmdLen = 3'd1;
  logic [7:0]  dataLen = '0;
  logic        isRead = 1'b0;
  logic [1:0]  dselClass = '0;
  logic [7:0]  dselOther = 8'd5;
  logic [7:0]  dselRead = 8'd9;
  logic [7:0]  dselProg = 8'd3;
  logic [7:0]  txData = '0;
  logic        txTake;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        holdReq = 1'b0;
  logic        csN, sclk, mosi, miso, holdN;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // bench-side slave and monitor state
  int bitN = 0;
  logic [7:0] curByte = '0;
  logic [7:0] capMosi [0:15];
  logic [7:0] rxBuf [0:15];
  int rxN = 0, takeN = 0, lowCnt = 0, highRun = 0, lastGap = 0, fallCnt = 0;
  int badHoldN = 0;
  logic prevCsN = 1'b1;
  int curCl = 1, curSeed = 0;

  always #10 clk = !clk;

  spi_xact_engine #(.CMD_BYTES(5), .LEN_W(8), .DIV(DIV), .DSEL_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .mode3(mode3),
    .cmdBuf(cmdBuf), .cmdLen(cmdLen), .dataLen(dataLen), .isRead(isRead),
    .dselClass(dselClass), .dselOther(dselOther), .dselRead(dselRead),
    .dselProg(dselProg), .txData(txData), .txTake(txTake), .rxData(rxData),
    .rxValid(rxValid), .holdReq(holdReq), .csN(csN), .sclk(sclk),
    .mosi(mosi), .miso(miso), .holdN(holdN)
  );

  function automatic logic [7:0] cmdVal(int i, int seed);
    return 8'(8'h11 * (i + 1) + seed);
  endfunction
  function automatic logic [7:0] txVal(int j, int seed);
    return 8'(8'hC3 + j * 29 + seed * 7);
  endfunction
  function automatic logic [7:0] rxVal(int j, int seed);
    return 8'(8'h5A ^ (j * 37) ^ (seed * 3));
  endfunction

  // miso: ones during command bytes, pattern during data bytes
  always_comb begin
    if ((bitN >> 3) < curCl) miso = 1'b1;
    else miso = rxVal((bitN >> 3) - curCl, curSeed) >> (7 - (bitN & 7));
  end

  always @(posedge sclk) begin
    if (!csN) begin
      curByte = {curByte[6:0], mosi};
      if ((bitN & 7) == 7 && (bitN >> 3) < 16) capMosi[bitN >> 3] = curByte;
      bitN = bitN + 1;
    end
  end

  always @(negedge clk) begin
    if (!csN) begin
      lowCnt = lowCnt + 1;
      if (prevCsN) begin
        lastGap = highRun;
        fallCnt = fallCnt + 1;
      end
      highRun = 0;
    end else begin
      highRun = highRun + 1;
    end
    prevCsN = csN;
    if (rxValid && rxN < 16) begin
      rxBuf[rxN] = rxData;
      rxN = rxN + 1;
    end
    if (txTake) begin
      takeN = takeN + 1;
      txData = txVal(takeN, curSeed);
    end
    if (!holdN && !holdReq) badHoldN = badHoldN + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == WD_LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WD_LIMIT);
      finishRun();
    end
  end

  // one transaction; optional hold and stray request at given offsets
  task automatic xact(input int cl, input int dl, input bit rd, input bit md,
                      input int seed, input int holdAt, input int holdLen,
                      input int pokeAt);
    int tot;
    int startFalls;
    int holdBad;
    int badBytes;
    logic sclkHeld;
    tot = cl + dl;
    @(negedge clk);
    curCl = cl; curSeed = seed;
    mode3 = md; cmdLen = 3'(cl); dataLen = 8'(dl); isRead = rd;
    dselClass = (dl == 0) ? 2'd0 : (rd ? 2'd1 : 2'd2);
    for (int i = 0; i < 5; i++) cmdBuf[8*i +: 8] = cmdVal(i, seed);
    bitN = 0; lowCnt = 0; rxN = 0; takeN = 0; holdBad = 0;
    txData = txVal(0, seed);
    startFalls = fallCnt;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (pokeAt > 0) begin
      repeat (pokeAt) @(negedge clk);
      cmdLen = 3'd2; cmdBuf[7:0] = 8'hEE;
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    if (holdLen > 0) begin
      repeat (holdAt) @(negedge clk);
      holdReq = 1'b1;
      sclkHeld = sclk;
      for (int k = 0; k < holdLen; k++) begin
        @(negedge clk);
        if (holdN || csN || sclk != sclkHeld) holdBad = holdBad + 1;
      end
      holdReq = 1'b0;
      check(holdBad == 0, "R8", "hold pin/cs/sclk during hold", holdBad, 0);
    end
    while (busy) @(negedge clk);
    // R1: frame length and byte order
    check(lowCnt == 16 * DIV * tot + holdLen, "R1", "csN low cycles",
          lowCnt, 16 * DIV * tot + holdLen);
    check(bitN == 8 * tot, "R2", "rising sclk edges", bitN, 8 * tot);
    badBytes = 0;
    for (int i = 0; i < tot && i < 16; i++) begin
      logic [7:0] e;
      if (i < cl) e = cmdVal(i, seed);
      else if (rd) e = 8'h00;
      else e = txVal(i - cl, seed);
      if (capMosi[i] !== e) begin
        badBytes = badBytes + 1;
        $display("FAIL R1 mosi byte %0d: actual %0d expected %0d", i, capMosi[i], e);
      end
    end
    check(badBytes == 0, rd ? "R4" : "R1", "mosi bytes", badBytes, 0);
    // R3/R4/R5 data strobes
    check(takeN == (rd ? 0 : dl), dl == 0 ? "R5" : "R3", "txTake pulses",
          takeN, rd ? 0 : dl);
    check(rxN == (rd ? dl : 0), dl == 0 ? "R5" : "R4", "rxValid pulses",
          rxN, rd ? dl : 0);
    if (rd) begin
      badBytes = 0;
      for (int j = 0; j < dl && j < 16; j++)
        if (rxBuf[j] !== rxVal(j, seed)) badBytes = badBytes + 1;
      check(badBytes == 0, "R4", "received bytes", badBytes, 0);
    end
    check(sclk == md, "R2", "sclk idle level", sclk, md);
    if (pokeAt > 0) begin
      repeat (12) @(negedge clk);
      check(fallCnt - startFalls == 1 && !busy, "R7", "transactions started",
            fallCnt - startFalls, 1);
    end
  endtask

  // back-to-back requests, measure csN gap for a class
  task automatic gapTest(input int cls, input int expD);
    int startFalls;
    @(negedge clk);
    curCl = 5; mode3 = 1'b0; cmdLen = 3'd1; dataLen = 8'd0; isRead = 1'b0;
    dselClass = 2'(cls);
    startFalls = fallCnt;
    reqValid = 1'b1;
    while (fallCnt < startFalls + 2) @(negedge clk);
    reqValid = 1'b0;
    check(lastGap == expD + 2, "R6", "csN high gap", lastGap, expD + 2);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    check(csN && holdN && !busy && !txTake && !rxValid && sclk == 1'b0,
          "R9", "reset outputs", {csN, holdN, busy, txTake, rxValid, sclk}, 6'b110000);
    rstN = 1'b1;
    @(negedge clk);
    mode3 = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R9", "idle sclk mode 3", sclk, 1);
    mode3 = 1'b0;
    // R1..R5 sweep
    for (int md = 0; md < 2; md++)
      for (int rd = 0; rd < 2; rd++)
        for (int cl = 1; cl <= 5; cl++)
          for (int dl = 0; dl <= 3; dl++)
            xact(cl, dl, rd[0], md[0], cl * 4 + dl + rd * 20 + md * 40, 0, 0, 0);
    // R6 deselect classes
    gapTest(0, 5);
    gapTest(1, 9);
    gapTest(2, 3);
    gapTest(3, 5);
    dselOther = 8'd0;
    gapTest(0, 0);
    dselOther = 8'd5;
    // R8 hold in mid-frame, write and read, both modes
    xact(4, 3, 1'b0, 1'b0, 77, 40, 25, 0);
    xact(5, 2, 1'b1, 1'b1, 91, 70, 13, 0);
    // R7 request while busy is ignored
    xact(3, 2, 1'b0, 1'b0, 55, 0, 0, 20);
    xact(2, 1, 1'b1, 1'b1, 66, 0, 0, 30);
    check(badHoldN == 0, "R8", "holdN low without hold", badHoldN, 0);
    finishRun();
  end

endmodule